// File: doc/BRIEF.md
# Count-Leading Instruction Decoder (Major Opcode Zero)

This block takes 32-bit instruction words whose top six bits are zero and handles a small group of function codes. Four of them count leading zero or leading one bits, in 32-bit or 64-bit form. The fifth is a software debug breakpoint. For a valid count, the block computes the count from a 64-bit source operand. It returns that count together with the destination register index taken from the instruction.

The count function codes are also used by older register-move encodings. A count is therefore valid only when the instruction carries a specific pattern in two otherwise-unused fields. Any other pattern raises a reserved-instruction flag. A mode input enables the 64-bit forms. When it is low, those forms trap as reserved.

Function codes that the block does not own are reported as not handled, so that a neighbouring decoder can claim them. The same applies to any word with a non-zero major opcode. Every output is registered and appears on the cycle after an input strobe.

Top module: `spec_cnt_decode`

## Requirements
- R1: Function codes 0x10 (count leading zeros) and 0x11 (count leading ones), with bits 31:26 zero, produce a result only when bits 20:16 equal 0 and bits 10:6 equal 1. Any other value in those fields raises `exc_rsv` and gives no result.
- R2: Bits 25:21 do not affect decoding or the result. Bits 15:11 are returned on `dst_idx` with each result.
- R3: The 32-bit counts look only at `src_op[31:0]` and return 0 to 32. An all-zero low word gives 32 for the zero count, and an all-ones low word gives 32 for the ones count.
- R4: Function codes 0x12 (zeros) and 0x13 (ones), with `wide_en` high and valid fields, count over all 64 source bits and return 0 to 64.
- R5: Function code 0x12 or 0x13 with `wide_en` low raises `exc_rsv`, even when the fields are valid.
- R6: Function code 0x0e with bits 31:26 zero always raises `exc_dbg`, whatever bits 25:6 hold.
- R7: A word with non-zero bits 31:26, or any function code other than 0x0e and 0x10 to 0x13, raises `not_mine` and no exception.
- R8: Outputs update on the clock edge after `in_valid`. A cycle with `in_valid` low gives all four strobes low on the next cycle. `dst_idx` and `cnt_val` hold their last result until the next valid count.
- R9: At most one of `res_valid`, `exc_rsv`, `exc_dbg` and `not_mine` is high in any cycle.
- R10: After synchronous reset, all strobes are low and `dst_idx` and `cnt_val` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word and operand are presented |
| instr | input | 32 | Instruction word |
| src_op | input | 64 | Source operand read from register rs |
| wide_en | input | 1 | 64-bit operations enabled |
| res_valid | output | 1 | A count result is present |
| dst_idx | output | 5 | Destination register index |
| cnt_val | output | 7 | Leading-bit count |
| exc_rsv | output | 1 | Reserved-instruction exception |
| exc_dbg | output | 1 | Debug-breakpoint exception |
| not_mine | output | 1 | Word belongs to another decoder |

## Verification
The block holds no state beyond one output register stage. A wrong classification therefore shows at the ports on the very next cycle, as the wrong strobe or as two strobes at once. A counter that is off by one, or that looks at the wrong half of the operand, shows up as a wrong `cnt_val` on that same cycle. Boundary operands exercise this: all zeros, all ones, a single top bit set, and patterns whose upper half differs from the lower half. A register that fails to clear or hold shows as stale strobes after an idle cycle, or as `dst_idx` and `cnt_val` changing without a result.

// File: rtl/spec_cnt_pkg.sv
package spec_cnt_pkg;
  localparam logic [5:0] FN_BRK  = 6'h0e;
  localparam logic [5:0] FN_CLZ  = 6'h10;
  localparam logic [5:0] FN_CLO  = 6'h11;
  localparam logic [5:0] FN_DCLZ = 6'h12;
  localparam logic [5:0] FN_DCLO = 6'h13;
  localparam logic [4:0] SA_KEY  = 5'd1;

  typedef enum logic [2:0] {
    K_NONE,
    K_CLZ,
    K_CLO,
    K_DCLZ,
    K_DCLO,
    K_BRK,
    K_RSV
  } kind_e;
endpackage

// File: rtl/spec_cnt_classify.sv
module spec_cnt_classify
  import spec_cnt_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  input  logic [4:0] rt,
  input  logic [4:0] sa,
  input  logic       wide_en,
  output kind_e      kind
);
  logic shape_ok;
  assign shape_ok = (rt == 5'd0) && (sa == SA_KEY);

  always_comb begin
    kind = K_NONE;
    if (opc == 6'd0) begin
      case (fn)
        FN_CLZ:  kind = shape_ok ? K_CLZ : K_RSV;
        FN_CLO:  kind = shape_ok ? K_CLO : K_RSV;
        FN_DCLZ: kind = (shape_ok && wide_en) ? K_DCLZ : K_RSV;
        FN_DCLO: kind = (shape_ok && wide_en) ? K_DCLO : K_RSV;
        FN_BRK:  kind = K_BRK;
        default: kind = K_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lead_bit_cnt.sv
module lead_bit_cnt #(
  parameter int W  = 32,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] cnt
);
  always_comb begin
    logic hit;
    hit = 1'b0;
    cnt = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit && vec[i]) begin
        cnt = CW'(W - 1 - i);
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/spec_cnt_decode.sv
module spec_cnt_decode
  import spec_cnt_pkg::*;
#(
  parameter int DATA_W = 64,
  localparam int HALF_W = DATA_W / 2,
  localparam int CNT_W  = $clog2(DATA_W + 1),
  localparam int HCNT_W = $clog2(HALF_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] src_op,
  input  logic              wide_en,
  output logic              res_valid,
  output logic [4:0]        dst_idx,
  output logic [CNT_W-1:0]  cnt_val,
  output logic              exc_rsv,
  output logic              exc_dbg,
  output logic              not_mine
);
  kind_e kind;
  logic  ones_mode;
  logic  is_cnt;
  logic  is_wide;
  logic [DATA_W-1:0] cnt_src;
  logic [HCNT_W-1:0] n_cnt;
  logic [CNT_W-1:0]  w_cnt;
  logic [CNT_W-1:0]  sel_cnt;
  logic unused_rs;

  assign unused_rs = ^instr[25:21];

  spec_cnt_classify u_cls (
    .opc     (instr[31:26]),
    .fn      (instr[5:0]),
    .rt      (instr[20:16]),
    .sa      (instr[10:6]),
    .wide_en (wide_en),
    .kind    (kind)
  );

  assign ones_mode = (kind == K_CLO) || (kind == K_DCLO);
  assign is_wide   = (kind == K_DCLZ) || (kind == K_DCLO);
  assign is_cnt    = (kind == K_CLZ) || (kind == K_CLO) || is_wide;
  assign cnt_src   = ones_mode ? ~src_op : src_op;

  lead_bit_cnt #(.W(HALF_W)) u_narrow (
    .vec (cnt_src[HALF_W-1:0]),
    .cnt (n_cnt)
  );

  lead_bit_cnt #(.W(DATA_W)) u_wide (
    .vec (cnt_src),
    .cnt (w_cnt)
  );

  assign sel_cnt = is_wide ? w_cnt : CNT_W'(n_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      exc_rsv   <= 1'b0;
      exc_dbg   <= 1'b0;
      not_mine  <= 1'b0;
      dst_idx   <= '0;
      cnt_val   <= '0;
    end else begin
      res_valid <= in_valid && is_cnt;
      exc_rsv   <= in_valid && (kind == K_RSV);
      exc_dbg   <= in_valid && (kind == K_BRK);
      not_mine  <= in_valid && (kind == K_NONE);
      if (in_valid && is_cnt) begin
        dst_idx <= instr[15:11];
        cnt_val <= sel_cnt;
      end
    end
  end
endmodule

// File: rtl/spec_cnt_decode_chk.sv
module spec_cnt_decode_chk #(
  parameter int DATA_W = 64,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [31:0]      instr,
  input logic             wide_en,
  input logic             res_valid,
  input logic [CNT_W-1:0] cnt_val,
  input logic             exc_rsv,
  input logic             exc_dbg,
  input logic             not_mine
);
  // R9
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({res_valid, exc_rsv, exc_dbg, not_mine}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !(res_valid || exc_rsv || exc_dbg || not_mine));

  // R6
  brk_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd0 && instr[5:0] == 6'h0e) |=> exc_dbg);

  // R7
  foreign_opc_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] != 6'd0) |=> not_mine);

  // R5
  wide_off_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_en && instr[31:26] == 6'd0 &&
     (instr[5:0] == 6'h12 || instr[5:0] == 6'h13)) |=> exc_rsv);

  // R1
  bad_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && instr[31:26] == 6'd0 &&
     (instr[5:0] == 6'h10 || instr[5:0] == 6'h11) &&
     (instr[20:16] != 5'd0 || instr[10:6] != 5'd1)) |=> exc_rsv);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (cnt_val <= CNT_W'(DATA_W)));

  // R8
  hold_val_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> $stable(cnt_val));
endmodule

bind spec_cnt_decode spec_cnt_decode_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .instr     (instr),
  .wide_en   (wide_en),
  .res_valid (res_valid),
  .cnt_val   (cnt_val),
  .exc_rsv   (exc_rsv),
  .exc_dbg   (exc_dbg),
  .not_mine  (not_mine)
);

// File: tb/spec_cnt_decode_bench.sv
module spec_cnt_decode_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] src_op = '0;
  logic        wide_en = 1'b0;
  logic        res_valid, exc_rsv, exc_dbg, not_mine;
  logic [4:0]  dst_idx;
  logic [6:0]  cnt_val;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // expected outputs for the next compare
  bit         e_vld, e_rsv, e_dbg, e_nm;
  logic [4:0] e_dst;
  logic [6:0] e_cnt;
  string      e_tag;

  always #4 clk = ~clk;

  spec_cnt_decode u_spec_cnt_decode (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .src_op(src_op), .wide_en(wide_en), .res_valid(res_valid),
    .dst_idx(dst_idx), .cnt_val(cnt_val), .exc_rsv(exc_rsv),
    .exc_dbg(exc_dbg), .not_mine(not_mine)
  );

  function automatic logic [31:0] mk(int opc, int rs, int rt, int rd, int sa, int fn);
    return {opc[5:0], rs[4:0], rt[4:0], rd[4:0], sa[4:0], fn[5:0]};
  endfunction

  function automatic int ref_lead(logic [63:0] v, int w, bit ones);
    int n = 0;
    bit stop = 0;
    for (int i = w - 1; i >= 0; i--) begin
      if (!stop && v[i] == ones) n++;
      else stop = 1;
    end
    return n;
  endfunction

  task automatic compare();
    compared++;
    if ({res_valid, exc_rsv, exc_dbg, not_mine} !== {e_vld, e_rsv, e_dbg, e_nm} ||
        dst_idx !== e_dst || cnt_val !== e_cnt) begin
      mismatched++;
      $display("FAIL %s: got vld=%0b rsv=%0b dbg=%0b nm=%0b dst=%0d cnt=%0d, want vld=%0b rsv=%0b dbg=%0b nm=%0b dst=%0d cnt=%0d",
               e_tag, res_valid, exc_rsv, exc_dbg, not_mine, dst_idx, cnt_val,
               e_vld, e_rsv, e_dbg, e_nm, e_dst, e_cnt);
    end
  endtask

  // compare the previous expectation, then drive a new word and model it
  task automatic step(bit v, logic [31:0] w, logic [63:0] s, bit we, string tag);
    int opc, fn, rt, sa;
    bit shape;
    @(negedge clk);
    compare();
    in_valid = v; instr = w; src_op = s; wide_en = we;
    opc = int'(w[31:26]); fn = int'(w[5:0]); rt = int'(w[20:16]); sa = int'(w[10:6]);
    shape = (rt == 0) && (sa == 1);
    e_tag = tag;
    e_vld = 0; e_rsv = 0; e_dbg = 0; e_nm = 0;
    if (v) begin
      if (opc != 0) e_nm = 1;
      else if (fn == 'h10 || fn == 'h11) begin
        if (shape) begin
          e_vld = 1; e_dst = w[15:11];
          e_cnt = 7'(ref_lead(s, 32, fn == 'h11));
        end else e_rsv = 1;
      end else if (fn == 'h12 || fn == 'h13) begin
        if (shape && we) begin
          e_vld = 1; e_dst = w[15:11];
          e_cnt = 7'(ref_lead(s, 64, fn == 'h13));
        end else e_rsv = 1;
      end else if (fn == 'h0e) e_dbg = 1;
      else e_nm = 1;
    end
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got hang, want completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    e_vld = 0; e_rsv = 0; e_dbg = 0; e_nm = 0; e_dst = '0; e_cnt = '0;
    e_tag = "R10 reset";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step(0, '0, '0, 0, "R10 reset state");
    // R3 32-bit counts
    step(1, mk(0, 3, 0, 7, 1, 'h10), 64'h0, 1, "R3 clz zero");
    step(1, mk(0, 3, 0, 8, 1, 'h11), 64'h0000_0000_FFFF_FFFF, 1, "R3 clo ones");
    step(1, mk(0, 3, 0, 9, 1, 'h10), 64'hFFFF_FFFF_0000_0001, 1, "R3 clz low only");
    step(1, mk(0, 3, 0, 10, 1, 'h10), 64'h0000_0000_8000_0000, 1, "R3 clz top bit");
    step(1, mk(0, 3, 0, 11, 1, 'h11), 64'h0000_0000_FFF0_0000, 1, "R3 clo twelve");
    // R4 64-bit counts
    step(1, mk(0, 1, 0, 12, 1, 'h12), 64'h0, 1, "R4 dclz zero");
    step(1, mk(0, 1, 0, 13, 1, 'h13), '1, 1, "R4 dclo ones");
    step(1, mk(0, 1, 0, 14, 1, 'h12), 64'h0000_0001_0000_0000, 1, "R4 dclz 31");
    step(1, mk(0, 1, 0, 15, 1, 'h13), 64'hFFFF_FFFF_FFFF_FFFE, 1, "R4 dclo 63");
    // R2 rs free, rd returned
    step(1, mk(0, 31, 0, 31, 1, 'h10), 64'h0000_0000_0000_00FF, 1, "R2 rs ignored rd 31");
    step(1, mk(0, 0, 0, 0, 1, 'h11), 64'h0000_0000_0000_00FF, 0, "R2 rd 0");
    // R1 invalid shapes
    step(1, mk(0, 0, 1, 4, 1, 'h10), 64'h5, 1, "R1 rt nonzero");
    step(1, mk(0, 0, 0, 4, 0, 'h11), 64'h5, 1, "R1 sa zero");
    step(1, mk(0, 0, 0, 4, 2, 'h12), 64'h5, 1, "R1 wide sa two");
    // R8 hold after exceptions
    step(0, mk(0, 0, 0, 4, 1, 'h10), 64'h5, 1, "R8 idle hold");
    // R5 wide disabled
    step(1, mk(0, 0, 0, 6, 1, 'h12), 64'h1, 0, "R5 dclz disabled");
    step(1, mk(0, 0, 0, 6, 1, 'h13), 64'h1, 0, "R5 dclo disabled");
    // R6 breakpoint
    step(1, mk(0, 31, 31, 31, 31, 'h0e), 64'h0, 0, "R6 brk all code ones");
    step(1, mk(0, 0, 0, 0, 0, 'h0e), 64'h0, 1, "R6 brk zero code");
    // R7 foreign
    step(1, mk(1, 0, 0, 3, 1, 'h10), 64'h0, 1, "R7 nonzero opcode");
    step(1, mk(0, 0, 0, 3, 1, 'h20), 64'h0, 1, "R7 other fn");
    step(1, mk(0, 0, 0, 3, 1, 'h0d), 64'h0, 1, "R7 fn below brk");
    step(0, '0, '0, 0, "R8 idle after foreign");
    // R9 mixed sweep
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      logic [63:0] s;
      int pick;
      pick = int'($urandom_range(0, 5));
      w = $urandom;
      if (pick < 4) begin
        w[31:26] = 0;
        w[5:0] = 6'h10 + 6'(pick);
        if ($urandom_range(0, 3) != 0) begin w[20:16] = 0; w[10:6] = 1; end
      end else if (pick == 4) begin
        w[31:26] = 0; w[5:0] = 6'h0e;
      end
      s = {$urandom, $urandom} >> $urandom_range(0, 63);
      if ($urandom_range(0, 1) == 1) s = ~s;
      step($urandom_range(0, 4) != 0, w, s, $urandom_range(0, 1) == 1, "R9 sweep");
    end
    step(0, '0, '0, 0, "R8 final idle");
    step(0, '0, '0, 0, "R8 final idle");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule